// File: doc/BRIEF.md
# Squeeze Kernel Sequencer

This block feeds a squeeze-stage convolution engine. It keeps kernel words and bias words in local RAM. On each accepted request it returns one group of sixteen kernel values and one bias. Eight values of the group belong to the squeeze weights that read the 3x3-expand results, and the other eight belong to the weights that read the 1x1-expand results. The RAM is written through plain write ports. Filling the RAM from external memory, the multiply-accumulate work and any pooling belong to other blocks.

After a start pulse, the block walks three nested counters. Input depth is the innermost counter and squeeze kernel is the middle one. The input row is the outer counter, so the whole kernel set is replayed for each new row. The kernel RAM address is kernel × depth_count + depth, and the row counter has no part in it. Two flags go with every group. One marks the first depth of a kernel and the other marks the last, so the accumulator knows when to clear and when to emit. When the final group of the last row is taken, the block raises done and stays idle until the next start.

Top module: `sqz_kernel_sequencer`

## Requirements
- R1: A start pulse latches the kernel count p, the depth count m and the row count (each a plain count of at least 1). It clears done and any pending group, and resets the walk to row 0, kernel 0, depth 0.
- R2: A request is accepted when the block is running and no group is pending, or when the pending group is acknowledged in that same cycle. grp_valid rises at the clock edge where the request is sampled. The group stays valid, with unchanged contents, until the edge where grp_ack is sampled high.
- R3: grp_k3 carries bits [HALF-1:0] and grp_k1 carries bits [2*HALF-1:HALF] of the kernel word stored at address kernel*m + depth.
- R4: Depth advances fastest, then kernel, then row. Every row replays all p*m kernel addresses from address 0, so a run delivers exactly p*m*rows groups.
- R5: Each group carries the bias word stored at bias address equal to the current kernel index.
- R6: grp_first is 1 exactly when the group's depth is 0, and grp_last is 1 exactly when the depth is m-1. Both are 1 when m = 1.
- R7: A request that arrives while a group is pending and not acknowledged is ignored. It does not advance the walk and does not produce a second group.
- R8: done rises at the edge where the final group is acknowledged. While done is high, no request produces a group, until the next start.
- R9: Before the first start after reset, requests are ignored. busy is high while a run is in progress or a group is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new run and latch the counts |
| cfg_kernels | input | PW | Squeeze kernel count p |
| cfg_depth | input | MW | Input depth count m |
| cfg_rows | input | ROW_W | Input row count |
| kwr_en | input | 1 | Kernel RAM write enable |
| kwr_addr | input | AW | Kernel RAM write address |
| kwr_data | input | 2*HALF | Kernel word: 3x3-side half low, 1x1-side half high |
| bwr_en | input | 1 | Bias RAM write enable |
| bwr_addr | input | BAW | Bias RAM write address |
| bwr_data | input | BW | Bias word |
| req | input | 1 | Request for the next group |
| grp_ack | input | 1 | Consumer takes the pending group |
| grp_valid | output | 1 | A group is pending |
| grp_k3 | output | HALF | Eight kernel values for the 3x3-expand inputs |
| grp_k1 | output | HALF | Eight kernel values for the 1x1-expand inputs |
| grp_bias | output | BW | Bias for the current kernel |
| grp_first | output | 1 | Group is at depth 0 |
| grp_last | output | 1 | Group is at depth m-1 |
| busy | output | 1 | Run in progress or group pending |
| done | output | 1 | Final group taken |

## Verification
The hardest case to reach is a request that lands while a group is still held unacknowledged. With free-flowing acknowledges it never happens. The stimulus therefore keeps req high and acknowledges only one cycle in four, and a second pattern randomises both req and ack. The reference model counts groups at the ports, which shows whether such a request was ignored or counted twice. Runs with m = 1 and with p and m at their maximum cover the points where the depth and kernel counters wrap.

// File: rtl/sqz_kernel_sequencer.sv
`timescale 1ns/1ps
module sqz_kernel_sequencer #(
  parameter int LANES = 8,
  parameter int KW    = 8,
  parameter int BW    = 16,
  parameter int P_MAX = 16,
  parameter int M_MAX = 16,
  parameter int ROW_W = 10,
  localparam int HALF  = LANES * KW,
  localparam int WORD  = 2 * HALF,
  localparam int PW    = $clog2(P_MAX + 1),
  localparam int MW    = $clog2(M_MAX + 1),
  localparam int DEPTH = P_MAX * M_MAX,
  localparam int AW    = $clog2(DEPTH),
  localparam int BAW   = $clog2(P_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PW-1:0]    cfg_kernels,
  input  logic [MW-1:0]    cfg_depth,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic             kwr_en,
  input  logic [AW-1:0]    kwr_addr,
  input  logic [WORD-1:0]  kwr_data,
  input  logic             bwr_en,
  input  logic [BAW-1:0]   bwr_addr,
  input  logic [BW-1:0]    bwr_data,
  input  logic             req,
  input  logic             grp_ack,
  output logic             grp_valid,
  output logic [HALF-1:0]  grp_k3,
  output logic [HALF-1:0]  grp_k1,
  output logic [BW-1:0]    grp_bias,
  output logic             grp_first,
  output logic             grp_last,
  output logic             busy,
  output logic             done
);

  logic [WORD-1:0] kmem [DEPTH];
  logic [BW-1:0]   bmem [P_MAX];

  logic             run_q, fin_q;
  logic [PW-1:0]    p_q, k_q;
  logic [MW-1:0]    m_q, d_q;
  logic [ROW_W-1:0] rows_q, r_q;
  logic [AW-1:0]    a_q;

  wire take   = grp_valid & grp_ack;
  wire issue  = run_q & req & (~grp_valid | take);
  wire last_d = MW'(d_q + 1'b1) == m_q;
  wire last_k = PW'(k_q + 1'b1) == p_q;
  wire last_r = ROW_W'(r_q + 1'b1) == rows_q;

  assign busy = run_q | grp_valid;

  always_ff @(posedge clk) begin
    if (kwr_en) kmem[kwr_addr] <= kwr_data;
    if (bwr_en) bmem[bwr_addr] <= bwr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; fin_q <= 1'b0; done <= 1'b0; grp_valid <= 1'b0;
      p_q <= '0; m_q <= '0; rows_q <= '0;
      k_q <= '0; d_q <= '0; r_q <= '0; a_q <= '0;
      grp_k3 <= '0; grp_k1 <= '0; grp_bias <= '0;
      grp_first <= 1'b0; grp_last <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1; fin_q <= 1'b0; done <= 1'b0; grp_valid <= 1'b0;
      p_q <= cfg_kernels; m_q <= cfg_depth; rows_q <= cfg_rows;
      k_q <= '0; d_q <= '0; r_q <= '0; a_q <= '0;
    end else begin
      if (take) grp_valid <= 1'b0;
      if (take && fin_q) done <= 1'b1;
      if (issue) begin
        grp_valid <= 1'b1;
        grp_k3    <= kmem[a_q][HALF-1:0];
        grp_k1    <= kmem[a_q][WORD-1:HALF];
        grp_bias  <= bmem[k_q[BAW-1:0]];
        grp_first <= d_q == '0;
        grp_last  <= last_d;
        if (!last_d) begin
          d_q <= MW'(d_q + 1'b1);
          a_q <= AW'(a_q + 1'b1);
        end else begin
          d_q <= '0;
          if (!last_k) begin
            k_q <= PW'(k_q + 1'b1);
            a_q <= AW'(a_q + 1'b1);
          end else begin
            k_q <= '0;
            a_q <= '0;
            if (!last_r) r_q <= ROW_W'(r_q + 1'b1);
            else begin
              run_q <= 1'b0;
              fin_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && !grp_ack && !start |=> grp_valid && $stable(grp_k3) && $stable(grp_k1) && $stable(grp_bias));

  assert_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_valid) |-> $past(req));

  assert_nodouble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && !grp_ack && !start |=> $stable(a_q) && $stable(d_q) && $stable(k_q));

  assert_single_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && m_q == MW'(1) |-> grp_first && grp_last);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !grp_valid && !run_q);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !grp_valid);

endmodule

// File: tb/sim_sqz_kernel_sequencer.sv
`timescale 1ns/1ps
module sim_sqz_kernel_sequencer;
  localparam int LANES = 8, KW = 8, BW = 16, P_MAX = 16, M_MAX = 16, ROW_W = 10;
  localparam int HALF = LANES * KW, WORD = 2 * HALF;
  localparam int PW = $clog2(P_MAX + 1), MW = $clog2(M_MAX + 1);
  localparam int DEPTH = P_MAX * M_MAX, AW = $clog2(DEPTH), BAW = $clog2(P_MAX);

  logic clk = 0, rst_n = 0, start = 0, req = 0, ack = 0;
  logic [PW-1:0] cfg_k = 1;
  logic [MW-1:0] cfg_m = 1;
  logic [ROW_W-1:0] cfg_r = 1;
  logic kwr_en = 0, bwr_en = 0;
  logic [AW-1:0] kwr_addr = '0;
  logic [WORD-1:0] kwr_data = '0;
  logic [BAW-1:0] bwr_addr = '0;
  logic [BW-1:0] bwr_data = '0;
  logic grp_valid, grp_first, grp_last, busy, done;
  logic [HALF-1:0] grp_k3, grp_k1;
  logic [BW-1:0] grp_bias;

  always #2.5 clk = ~clk;

  sqz_kernel_sequencer #(.LANES(LANES), .KW(KW), .BW(BW), .P_MAX(P_MAX), .M_MAX(M_MAX), .ROW_W(ROW_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_kernels(cfg_k), .cfg_depth(cfg_m), .cfg_rows(cfg_r),
    .kwr_en(kwr_en), .kwr_addr(kwr_addr), .kwr_data(kwr_data),
    .bwr_en(bwr_en), .bwr_addr(bwr_addr), .bwr_data(bwr_data),
    .req(req), .grp_ack(ack), .grp_valid(grp_valid), .grp_k3(grp_k3), .grp_k1(grp_k1),
    .grp_bias(grp_bias), .grp_first(grp_first), .grp_last(grp_last), .busy(busy), .done(done));

  int checks = 0, errors = 0, cycles = 0, port_cnt = 0;
  logic [WORD-1:0] refk [DEPTH];
  logic [BW-1:0]   refb [P_MAX];

  // behavioural reference
  int mp, mm, mr, mk, md, mrow;
  bit mrun, mfin, mdone, mval, ef, el;
  logic [HALF-1:0] e3, e1;
  logic [BW-1:0] eb;

  always @(posedge clk) begin : model
    bit tk, iss;
    cycles++;
    if (!rst_n) begin
      mrun = 0; mfin = 0; mdone = 0; mval = 0;
    end else if (start) begin
      mrun = 1; mfin = 0; mdone = 0; mval = 0;
      mp = cfg_k; mm = cfg_m; mr = cfg_r; mk = 0; md = 0; mrow = 0; port_cnt = 0;
    end else begin
      tk = mval && ack;
      iss = mrun && req && (!mval || tk);
      if (tk) begin
        mval = 0; port_cnt++;
        if (mfin) mdone = 1;
      end
      if (iss) begin
        mval = 1;
        e3 = refk[mk * mm + md][HALF-1:0];
        e1 = refk[mk * mm + md][WORD-1:HALF];
        eb = refb[mk];
        ef = (md == 0); el = (md == mm - 1);
        md++;
        if (md == mm) begin
          md = 0; mk++;
          if (mk == mp) begin
            mk = 0; mrow++;
            if (mrow == mr) begin mrun = 0; mfin = 1; end
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(grp_valid == mval, "R2 valid", 128'(grp_valid), 128'(mval));
    chk(done == mdone, "R8 done", 128'(done), 128'(mdone));
    chk(busy == (mrun | mval), "R9 busy", 128'(busy), 128'(mrun | mval));
    if (mval && grp_valid) begin
      chk(grp_k3 == e3, "R3 k3 half", 128'(grp_k3), 128'(e3));
      chk(grp_k1 == e1, "R3 k1 half", 128'(grp_k1), 128'(e1));
      chk(grp_bias == eb, "R5 bias", 128'(grp_bias), 128'(eb));
      chk(grp_first == ef, "R6 first", 128'(grp_first), 128'(ef));
      chk(grp_last == el, "R6 last", 128'(grp_last), 128'(el));
    end
  end

  always @(posedge clk) if (cycles > 150000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic do_start(int p, int m, int r);
    @(negedge clk);
    cfg_k = PW'(p); cfg_m = MW'(m); cfg_r = ROW_W'(r); start = 1; req = 0; ack = 0;
    @(negedge clk);
    start = 0;
  endtask

  // mode 0: free flow, 1: random, 2: ack one cycle in four
  task automatic run(int mode);
    int n = 0;
    while (!mdone && n < 20000) begin
      @(negedge clk);
      case (mode)
        0: begin req = 1; ack = 1; end
        1: begin req = 1'($urandom_range(0, 1)); ack = 1'($urandom_range(0, 1)); end
        default: begin req = 1; ack = (n % 4 == 3); end
      endcase
      n++;
    end
    @(negedge clk);
    req = 0; ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(grp_valid == 0 && done == 0 && busy == 0, "R1 reset state", 128'({grp_valid, done, busy}), 128'(0));
    for (int i = 0; i < DEPTH; i++) begin
      kwr_en = 1; kwr_addr = AW'(i);
      kwr_data = {$urandom(), $urandom(), $urandom(), $urandom()};
      refk[i] = kwr_data;
      if (i < P_MAX) begin
        bwr_en = 1; bwr_addr = BAW'(i); bwr_data = BW'($urandom()); refb[i] = bwr_data;
      end else bwr_en = 0;
      @(negedge clk);
    end
    kwr_en = 0; bwr_en = 0;

    req = 1; ack = 1;
    repeat (5) @(negedge clk);
    chk(grp_valid == 0 && busy == 0, "R9 request before start", 128'({grp_valid, busy}), 128'(0));

    do_start(3, 4, 2); run(0);
    chk(port_cnt == 24, "R4 group count p*m*rows", 128'(port_cnt), 128'(24));
    chk(done == 1, "R8 done after final take", 128'(done), 128'(1));
    req = 1; ack = 1;
    repeat (6) @(negedge clk);
    chk(grp_valid == 0 && done == 1, "R8 requests after done", 128'({grp_valid, done}), 128'(2'b01));
    req = 0; ack = 0;

    do_start(2, 1, 3); run(1);
    chk(port_cnt == 6, "R6 single depth run count", 128'(port_cnt), 128'(6));

    do_start(5, 3, 2); run(2);
    chk(port_cnt == 30, "R7 held requests not doubled", 128'(port_cnt), 128'(30));

    do_start(16, 16, 1); run(0);
    chk(port_cnt == 256, "R3 full RAM sweep", 128'(port_cnt), 128'(256));

    do_start(2, 2, 1);
    req = 1; ack = 1;
    repeat (3) @(negedge clk);
    do_start(1, 2, 2);
    chk(grp_valid == 0 && done == 0 && port_cnt == 0, "R1 restart clears", 128'({grp_valid, done}), 128'(0));
    run(1);
    chk(port_cnt == 4, "R1 restart count", 128'(port_cnt), 128'(4));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule